// File: doc/BRIEF.md
# Alternating Fixed-Width Pulse Formatter

This block turns two streams of single-cycle rate events into output pulses that can drive physical loads. The low-rate events go in turn to two active-low outputs. The pair suits a two-phase stepper motor or an electromechanical counter. The first event after reset lands on `f1_n`, the next on `f2_n`, and so on. The high-rate events drive one active-high output, `fout`, which is meant for calibration equipment. Each output has a nominal width, set in microseconds and converted to master-clock cycles at elaboration. When events come so fast that the nominal width would fill at least half of an output's own period, the width shrinks to half that period.

Each path measures the spacing between events by counting clock cycles. This counter saturates, so a long idle always counts as slow. The interval that ends at an event sets the width of the pulse that event starts. On the low-rate pair, each output's period is two event intervals, so the half-period width equals one interval. If an event arrives while its own output is still active, the running pulse ends, the output stays inactive for one cycle, and then a fresh pulse starts. Every event therefore remains visible as its own pulse. All outputs change only on the rising clock edge.

Top module: `alt_pulse_formatter`

## Requirements
- R1: While `rst_n` is low, `f1_n` and `f2_n` are high and `fout` is low. They stay that way until the first event arrives.
- R2: Each low-rate event produces exactly one low pulse, on `f1_n` or on `f2_n`. The first event after reset goes to `f1_n`, and later events alternate between the two outputs.
- R3: The nominal low width is LW = floor(CLK_HZ × LOW_WIDTH_US / 1e6) cycles. When the event interval is at least LW, the pulse is LW cycles long. The output changes on the same edge that samples the event.
- R4: When the low-rate event interval I is below LW, the pulse is I cycles long. This is half of the per-output period of 2·I.
- R5: Under a steady low-rate event interval I, the falling edges of successive pulses on the two outputs are I cycles apart, which is half the period of either output.
- R6: The nominal high width is HW = floor(CLK_HZ × HIGH_WIDTH_US / 1e6) cycles. When the high-rate interval is at least 2·HW, `fout` pulses are HW cycles long.
- R7: When the high-rate interval I is below 2·HW, the `fout` pulse lasts floor(I/2) cycles, and never less than one cycle.
- R8: Each interval counter saturates at twice its nominal width, and reset loads it at that saturated value. As a result, the first event after reset, and the first event after an idle of at least that length, uses the nominal width.
- R9: An event that arrives while its own output is still active ends the running pulse. The output is then inactive for exactly one cycle and carries a new pulse with the width chosen from the latest interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_tick | input | 1 | Single-cycle low-rate event |
| high_tick | input | 1 | Single-cycle high-rate event |
| f1_n | output | 1 | First alternating active-low pulse output |
| f2_n | output | 1 | Second alternating active-low pulse output |
| fout | output | 1 | Active-high pulse output for the high-rate events |

## Verification
The low-rate pair is driven at an interval well above the nominal width, exactly at it, and one cycle below it. These three runs separate the fixed-width branch from the interval-width branch at the threshold. The same runs check the alternation and the half-period edge spacing. The high-rate path is driven at a slow spacing, at exactly twice its width, and at an odd spacing below that. The odd spacing exposes any rounding error in the halving. Two further patterns exercise the restart rule: an event that cuts into a nominal-width pulse, and back-to-back events. The back-to-back case also checks the one-cycle minimum width.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;

   // Whole clock cycles in a span given in microseconds (rounded down).
   function automatic longint unsigned us_to_cycles(longint unsigned clk_hz,
                                                    longint unsigned span_us);
      return (clk_hz * span_us) / 64'd1_000_000;
   endfunction

endpackage

// File: rtl/pfmt_interval_meter.sv
module pfmt_interval_meter #(
   parameter int unsigned CW  = 8,
   parameter int unsigned SAT = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   output logic [CW-1:0] interval
);
   localparam logic [CW-1:0] SAT_V = CW'(SAT);

   initial begin : p_param_chk
      assert (SAT >= 2 && SAT < (64'd1 << CW))
         else $error("pfmt_interval_meter: SAT does not fit CW");
   end

   logic [CW-1:0] cnt_q;

   // Cycles since the previous tick; starts saturated so a first tick reads as slow.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= SAT_V;
      else if (tick)           cnt_q <= CW'(1);
      else if (cnt_q != SAT_V) cnt_q <= cnt_q + 1'b1;
   end

   assign interval = cnt_q;

   // R8
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (interval == SAT_V) && !tick |=> interval == SAT_V);

endmodule

// File: rtl/pfmt_width_sel.sv
module pfmt_width_sel #(
   parameter int unsigned CW   = 8,
   parameter int unsigned W    = 10,
   parameter int unsigned SPAN = 1
) (
   input  logic [CW-1:0] interval,
   output logic [CW-1:0] width
);
   localparam logic [CW-1:0] W_V  = CW'(W);
   localparam logic [CW-1:0] W2_V = CW'(2 * W);

   initial begin : p_param_chk
      assert (W >= 1 && (64'd2 * W) < (64'd1 << CW))
         else $error("pfmt_width_sel: width does not fit CW");
      assert (SPAN == 1 || SPAN == 2)
         else $error("pfmt_width_sel: SPAN must be 1 or 2");
   end

   generate
      if (SPAN == 2) begin : g_pair
         // Each output sees every second tick: half its period is one interval.
         assign width = (interval < W_V) ? interval : W_V;
      end else begin : g_single
         logic [CW-1:0] half;
         assign half  = interval >> 1;
         assign width = (interval < W2_V) ? ((half == '0) ? CW'(1) : half) : W_V;
      end
   endgenerate

endmodule

// File: rtl/pfmt_pulse_gen.sv
module pfmt_pulse_gen #(
   parameter int unsigned CW         = 8,
   parameter int unsigned WMAX       = 10,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] width,
   output logic          pin
);
   localparam logic [CW-1:0] WMAX_V = CW'(WMAX);

   initial begin : p_param_chk
      assert (WMAX >= 1 && WMAX < (64'd1 << CW))
         else $error("pfmt_pulse_gen: WMAX does not fit CW");
   end

   logic          on_q;
   logic          rs_q;
   logic [CW-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         rs_q  <= 1'b0;
         rem_q <= '0;
      end else if (start && !on_q) begin
         on_q  <= 1'b1;
         rs_q  <= 1'b0;
         rem_q <= width - 1'b1;
      end else if (start) begin
         // cut the running pulse, one idle cycle, then the new one
         on_q  <= 1'b0;
         rs_q  <= 1'b1;
         rem_q <= width;
      end else if (rs_q) begin
         on_q  <= 1'b1;
         rs_q  <= 1'b0;
         rem_q <= rem_q - 1'b1;
      end else if (on_q) begin
         if (rem_q == '0) on_q  <= 1'b0;
         else             rem_q <= rem_q - 1'b1;
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign pin = ~on_q;
      end else begin : g_high
         assign pin = on_q;
      end
   endgenerate

   // R3
   start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !on_q |=> on_q);

   // R9
   restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && on_q |=> !on_q);

   // R9
   restart_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && on_q ##1 !start |=> on_q);

   // R7
   width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (width != '0) && (width <= WMAX_V));

endmodule

// File: rtl/alt_pulse_formatter.sv
module alt_pulse_formatter #(
   parameter int unsigned CLK_HZ        = 3_580_000,
   parameter int unsigned LOW_WIDTH_US  = 275_000,
   parameter int unsigned HIGH_WIDTH_US = 90_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic low_tick,
   input  logic high_tick,
   output logic f1_n,
   output logic f2_n,
   output logic fout
);
   localparam int unsigned LOW_W  = 32'(pfmt_pkg::us_to_cycles(64'(CLK_HZ), 64'(LOW_WIDTH_US)));
   localparam int unsigned HIGH_W = 32'(pfmt_pkg::us_to_cycles(64'(CLK_HZ), 64'(HIGH_WIDTH_US)));
   localparam int unsigned LCW    = $clog2(4 * LOW_W + 2);
   localparam int unsigned HCW    = $clog2(4 * HIGH_W + 2);

   initial begin : p_param_chk
      assert (LOW_W >= 1 && HIGH_W >= 1)
         else $error("alt_pulse_formatter: a width rounds to zero cycles");
   end

   // ---------------- low-rate pair ----------------
   logic [LCW-1:0] low_ival;
   logic [LCW-1:0] low_width;
   logic           steer_q;
   logic [1:0]     low_pins;

   pfmt_interval_meter #(.CW(LCW), .SAT(2 * LOW_W)) low_meter_i (
      .clk(clk), .rst_n(rst_n), .tick(low_tick), .interval(low_ival));

   pfmt_width_sel #(.CW(LCW), .W(LOW_W), .SPAN(2)) low_wsel_i (
      .interval(low_ival), .width(low_width));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        steer_q <= 1'b0;
      else if (low_tick) steer_q <= ~steer_q;
   end

   for (genvar g = 0; g < 2; g++) begin : g_phase
      pfmt_pulse_gen #(.CW(LCW), .WMAX(LOW_W), .ACTIVE_LOW(1'b1)) phase_i (
         .clk(clk), .rst_n(rst_n),
         .start(low_tick && (steer_q == 1'(g))),
         .width(low_width), .pin(low_pins[g]));
   end

   assign f1_n = low_pins[0];
   assign f2_n = low_pins[1];

   // ---------------- high-rate output ----------------
   logic [HCW-1:0] high_ival;
   logic [HCW-1:0] high_width;

   pfmt_interval_meter #(.CW(HCW), .SAT(2 * HIGH_W)) high_meter_i (
      .clk(clk), .rst_n(rst_n), .tick(high_tick), .interval(high_ival));

   pfmt_width_sel #(.CW(HCW), .W(HIGH_W), .SPAN(1)) high_wsel_i (
      .interval(high_ival), .width(high_width));

   pfmt_pulse_gen #(.CW(HCW), .WMAX(HIGH_W), .ACTIVE_LOW(1'b0)) high_gen_i (
      .clk(clk), .rst_n(rst_n), .start(high_tick),
      .width(high_width), .pin(fout));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |-> f1_n && f2_n && !fout);

   // R2
   no_dual_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(f1_n) |-> !$fell(f2_n));

   // R6
   fout_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fout) |-> $past(high_tick) || $past(high_tick, 2));

endmodule

// File: tb/alt_pulse_formatter_tb_top.sv
`timescale 1ns/1ps
module alt_pulse_formatter_tb_top;
   localparam int LW = 40;   // 1 MHz, 40 us
   localparam int HW = 10;   // 1 MHz, 10 us
   localparam int NLOG = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic low_tick = 1'b0;
   logic high_tick = 1'b0;
   logic f1_n, f2_n, fout;

   int checks = 0;
   int failures = 0;
   int lowsent = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   alt_pulse_formatter #(.CLK_HZ(1_000_000), .LOW_WIDTH_US(40), .HIGH_WIDTH_US(10)) dut_i (
      .clk(clk), .rst_n(rst_n), .low_tick(low_tick), .high_tick(high_tick),
      .f1_n(f1_n), .f2_n(f2_n), .fout(fout));

   // ---------------- pulse monitor (samples at falling edge) ----------------
   int cyc = 0;
   int ls [2][NLOG];
   int lw [2][NLOG];
   int lc [2] = '{0, 0};
   int lst [2] = '{0, 0};
   logic lprev [2] = '{1'b1, 1'b1};
   int hs [NLOG];
   int hw [NLOG];
   int hc = 0;
   int hst = 0;
   logic hprev = 1'b0;

   always @(negedge clk) begin
      logic cur;
      cyc++;
      for (int ch = 0; ch < 2; ch++) begin
         cur = (ch == 0) ? f1_n : f2_n;
         if (lprev[ch] === 1'b1 && cur === 1'b0) lst[ch] = cyc;
         if (lprev[ch] === 1'b0 && cur === 1'b1) begin
            if (lc[ch] < NLOG) begin
               ls[ch][lc[ch]] = lst[ch];
               lw[ch][lc[ch]] = cyc - lst[ch];
            end
            lc[ch]++;
         end
         lprev[ch] = cur;
      end
      if (hprev === 1'b0 && fout === 1'b1) hst = cyc;
      if (hprev === 1'b1 && fout === 1'b0) begin
         if (hc < NLOG) begin
            hs[hc] = hst;
            hw[hc] = cyc - hst;
         end
         hc++;
      end
      hprev = fout;
   end

   // ---------------- helpers ----------------
   task automatic check_int(string req, string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic train(bit hi, int n, int gap);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         if (hi) high_tick = 1'b1; else low_tick = 1'b1;
         @(posedge clk); #1;
         high_tick = 1'b0;
         low_tick  = 1'b0;
         repeat (gap - 2) @(posedge clk);
      end
   endtask

   task automatic settle();
      repeat (300) @(posedge clk);
      #1;
   endtask

   function automatic int low_exp(int j, int gap);
      if (j == 0) return LW;               // R8: idle before the train
      return (gap < LW) ? gap : LW;
   endfunction

   function automatic int high_exp(int j, int gap);
      if (j == 0) return HW;               // R8
      if (gap < 2 * HW) return (gap / 2 == 0) ? 1 : gap / 2;
      return HW;
   endfunction

   // ---------------- scenarios ----------------
   task automatic test_reset();
      repeat (3) @(negedge clk);
      check_int("R1", "f1_n in reset", int'(f1_n), 1);
      check_int("R1", "f2_n in reset", int'(f2_n), 1);
      check_int("R1", "fout in reset", int'(fout), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check_int("R1", "no pulse after release", int'(f1_n) + int'(f2_n) - int'(fout), 2);
   endtask

   task automatic test_low(int n, int gap, string req);
      int base [2];
      int k [2];
      int prev_s = 0;
      base[0] = lc[0]; base[1] = lc[1];
      k[0] = 0; k[1] = 0;
      train(1'b0, n, gap);
      settle();
      for (int j = 0; j < n; j++) begin
         int ch = (lowsent + j) % 2;
         int idx = base[ch] + k[ch];
         k[ch]++;
         check_int((j == 0) ? "R8" : req, $sformatf("low pulse %0d width (gap %0d)", j, gap),
                   lw[ch][idx], low_exp(j, gap));
         if (j > 0)
            check_int("R5", $sformatf("falling edge spacing %0d (gap %0d)", j, gap),
                      ls[ch][idx] - prev_s, gap);
         prev_s = ls[ch][idx];
      end
      check_int("R2", "pulses on f1_n", lc[0] - base[0], k[0]);
      check_int("R2", "pulses on f2_n", lc[1] - base[1], k[1]);
      lowsent += n;
   endtask

   task automatic test_high(int n, int gap, string req);
      int base = hc;
      train(1'b1, n, gap);
      settle();
      check_int(req, $sformatf("fout pulse count (gap %0d)", gap), hc - base, n);
      for (int j = 0; j < n; j++)
         check_int((j == 0) ? "R8" : req, $sformatf("fout pulse %0d width (gap %0d)", j, gap),
                   hw[base + j], high_exp(j, gap));
   endtask

   task automatic test_restart_cut();
      int base = hc;
      train(1'b1, 2, 4);   // second tick lands inside a nominal-width pulse
      settle();
      check_int("R9", "pulse count after cut", hc - base, 2);
      check_int("R9", "cut pulse width", hw[base], 4);
      check_int("R9", "idle cycles between", hs[base + 1] - (hs[base] + hw[base]), 1);
      check_int("R9", "new pulse width", hw[base + 1], 2);
   endtask

   task automatic test_back_to_back();
      int base = hc;
      @(posedge clk); #1 high_tick = 1'b1;
      repeat (6) @(posedge clk);
      #1 high_tick = 1'b0;
      settle();
      check_int("R9", "pulses from six adjacent ticks", hc - base, 4);
      for (int j = 0; j < 4; j++)
         check_int("R7", $sformatf("minimum width pulse %0d", j), hw[base + j], 1);
   endtask

   // ---------------- main / watchdog ----------------
   initial begin
      test_reset();
      test_low(3, 100, "R3");
      test_low(3, LW, "R3");
      test_low(5, LW - 1, "R4");
      test_low(4, 24, "R4");
      test_high(3, 50, "R6");
      test_high(3, 2 * HW, "R6");
      test_high(4, 2 * HW - 1, "R7");
      test_high(4, 13, "R7");
      test_restart_cut();
      test_back_to_back();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150_000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule